// File: doc/BRIEF.md
# Hashed Mutex Ring

This block keeps coherence traffic for any one cache block serialized. It keeps a small set of mutex tokens that circulate on a ring. A node that wants to start a coherence transaction presents the block address. The address is hashed to one token, and that token is named by a lane and a time slot in a four-slot rotation. The node waits until that token passes its position. It takes the token off the ring, runs its transaction while holding it, and then puts it back.

The ring is modelled as a bit vector with one bit per token, where a set bit means the token is circulating. A two-bit phase counter says which slot is passing the nodes in the current cycle. Within one cycle, the passing token visits the nodes in index order, lowest first. A lower-indexed node therefore has the first chance at a free token. A node returning a token gives it to the nodes after it in that same cycle, and to the nodes before it only on the next rotation.

Top module: `hashed_mutex_ring`

## Requirements
- R1: A token is never held by two nodes at once, and in every cycle each token is either on the ring (its `ring_state` bit is 1) or held by exactly one node. A node holds a token from its `won` pulse until the token goes back on the ring.
- R2: An address maps to lane = `addr[LANE_LSB +: log2(LANES)]` and slot = `addr[SLOT_LSB +: 2]`. No other address bit affects the choice. The token's bit in `ring_state` is at index lane*4 + slot.
- R3: In a given cycle, only the tokens whose slot equals `ring_phase` can change state. A node that is not competing for a passing token leaves it on the ring.
- R4: A request is captured at the first clock edge where `acq_req` is high and the node is idle. If the phase seen after that edge is ph and the token is free, `won` goes high for exactly one cycle after ((slot − ph) mod 4) + 1 further edges. The token's ring bit clears at that same edge, so a free token is won within 4 cycles of capture.
- R5: When several waiting nodes compete for the same passing free token, the lowest-indexed one takes it.
- R6: A `rel_req` pulse seen while holding makes the node return the token. If the phase after that edge is ph, the token goes back at the edge that ends the first cycle whose phase equals its slot, which is ((slot − ph) mod 4) + 1 edges later. A higher-indexed waiter can take the token at that same edge. A lower-indexed waiter gets it 4 cycles later.
- R7: While `rst` is high (synchronous, active high), every `ring_state` bit is 1, `ring_phase` is 0 and `won` is 0.
- R8: `ring_phase` counts up by one each cycle, modulo 4.
- R9: `acq_req` and `acq_addr` are ignored while a node is waiting, holding or returning. The token it waits for is still the one captured first. `rel_req` is ignored while a node is not holding, so `ring_state` does not change.
- R10: Nodes waiting for tokens in different lanes with the same slot each win in the same cycle, without interfering with each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | NODES | Per-node acquire request, held high until `won` |
| acq_addr | input | NODES*ADDR_W | Per-node block address; node i uses bits [i*ADDR_W +: ADDR_W] |
| rel_req | input | NODES | Per-node one-cycle release strobe |
| won | output | NODES | Per-node one-cycle pulse: token taken |
| ring_state | output | LANES*4 | Token presence bits, index lane*4+slot |
| ring_phase | output | 2 | Slot currently passing the nodes |

## Verification
The bench sweeps every node against every lane and slot, and predicts the won edge and the return edge from the phase it observes. A hash that picked the wrong bits, or a grant that ignored the slot timing, would show up as a pulse on the wrong cycle or a cleared bit at the wrong index. Contention is tested in both ring orders. A design that ignored index priority, or that let a returned token reach an upstream node in the same cycle, would grant the wrong node or grant too early. A bench monitor tracks every token's holder and catches lost or duplicated tokens. Directed cases show that stray releases and late address changes are ignored, which a design that re-sampled its inputs would get wrong.

// File: rtl/hmr_pkg.sv
package hmr_pkg;
  localparam int RING_SLOTS = 4;
  localparam int SLOT_W     = 2;

  typedef enum logic [1:0] {
    ND_IDLE   = 2'd0,
    ND_WAIT   = 2'd1,
    ND_HOLD   = 2'd2,
    ND_RETURN = 2'd3
  } node_st_e;
endpackage

// File: rtl/hmr_node.sv
module hmr_node
  import hmr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int LANE_W   = 2,
  parameter int LANE_LSB = 8,
  parameter int SLOT_LSB = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rel,
  input  logic [SLOT_W-1:0] phase,
  input  logic              take,
  output logic              want,
  output logic              give,
  output logic              owns,
  output logic              won,
  output logic [LANE_W-1:0] lane,
  output logic [SLOT_W-1:0] slot
);
  node_st_e          st_q;
  logic [LANE_W-1:0] lane_q;
  logic [SLOT_W-1:0] slot_q;
  logic              addr_unused;

  // only the hash fields select a token
  assign addr_unused = ^addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ND_IDLE;
      lane_q <= '0;
      slot_q <= '0;
      won    <= 1'b0;
    end else begin
      won <= 1'b0;
      case (st_q)
        ND_IDLE: if (req) begin
          st_q   <= ND_WAIT;
          lane_q <= addr[LANE_LSB +: LANE_W];
          slot_q <= addr[SLOT_LSB +: SLOT_W];
        end
        ND_WAIT: if (take) begin
          st_q <= ND_HOLD;
          won  <= 1'b1;
        end
        ND_HOLD:   if (rel) st_q <= ND_RETURN;
        ND_RETURN: if (phase == slot_q) st_q <= ND_IDLE;
        default:   st_q <= ND_IDLE;
      endcase
    end
  end

  assign want = (st_q == ND_WAIT);
  assign give = (st_q == ND_RETURN) && (phase == slot_q);
  assign owns = (st_q == ND_HOLD) || (st_q == ND_RETURN);
  assign lane = lane_q;
  assign slot = slot_q;

  // R4: the ring only grants to a node that is waiting
  a_r4_take_only_waiting: assert property (@(posedge clk) disable iff (rst)
    take |-> (st_q == ND_WAIT));

  // R4: won lasts a single cycle
  a_r4_won_pulse: assert property (@(posedge clk) disable iff (rst)
    won |=> !won);

  // R9: the owned token key cannot be changed by new requests
  a_r9_key_stable: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ND_HOLD) || (st_q == ND_RETURN)) |=> ($stable(lane_q) && $stable(slot_q)));
endmodule

// File: rtl/hmr_ring.sv
module hmr_ring
  import hmr_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NODES-1:0]         want,
  input  logic [NODES-1:0]         give,
  input  logic [NODES*LANE_W-1:0]  lanes,
  input  logic [NODES*SLOT_W-1:0]  slots,
  output logic [NODES-1:0]         take,
  output logic [LANES*RING_SLOTS-1:0] ring_q,
  output logic [SLOT_W-1:0]        phase_q
);
  localparam int M     = LANES * RING_SLOTS;
  localparam int IDX_W = LANE_W + SLOT_W;

  logic [M-1:0] ring_d;
  logic [M-1:0] pass_mask;

  // one passing token per lane visits nodes 0..NODES-1 in order
  always_comb begin
    logic             cur;
    logic             hit;
    logic [IDX_W-1:0] idx;
    take      = '0;
    ring_d    = ring_q;
    pass_mask = '0;
    for (int l = 0; l < LANES; l++) begin
      idx            = {LANE_W'(l), phase_q};
      pass_mask[idx] = 1'b1;
      cur            = ring_q[idx];
      for (int i = 0; i < NODES; i++) begin
        hit = (lanes[i*LANE_W +: LANE_W] == LANE_W'(l)) &&
              (slots[i*SLOT_W +: SLOT_W] == phase_q);
        if (give[i] && hit) begin
          cur = 1'b1;
        end else if (want[i] && hit && cur) begin
          cur     = 1'b0;
          take[i] = 1'b1;
        end
      end
      ring_d[idx] = cur;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_q  <= '1;
      phase_q <= '0;
    end else begin
      ring_q  <= ring_d;
      phase_q <= phase_q + 1'b1;
    end
  end

  // R3: tokens not passing this cycle keep their state
  a_r3_other_slots_stable: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((ring_q ^ $past(ring_q)) & ~$past(pass_mask)) == '0));

  // R8: rotation advances by one slot per cycle
  a_r8_phase_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_q == $past(phase_q) + 2'd1));
endmodule

// File: rtl/hashed_mutex_ring.sv
module hashed_mutex_ring
  import hmr_pkg::*;
#(
  parameter int NODES    = 4,
  parameter int LANES    = 4,
  parameter int ADDR_W   = 16,
  parameter int SLOT_LSB = 6,
  parameter int LANE_LSB = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NODES-1:0]          acq_req,
  input  logic [NODES*ADDR_W-1:0]   acq_addr,
  input  logic [NODES-1:0]          rel_req,
  output logic [NODES-1:0]          won,
  output logic [LANES*RING_SLOTS-1:0] ring_state,
  output logic [SLOT_W-1:0]         ring_phase
);
  localparam int LANE_W = $clog2(LANES);
  localparam int M      = LANES * RING_SLOTS;
  localparam int IDX_W  = LANE_W + SLOT_W;

  logic [NODES-1:0]        want, give, owns, take;
  logic [NODES*LANE_W-1:0] lanes;
  logic [NODES*SLOT_W-1:0] slots;
  logic [M-1:0]            ring_q;
  logic [SLOT_W-1:0]       phase_q;

  for (genvar g = 0; g < NODES; g++) begin : g_node
    hmr_node #(
      .ADDR_W  (ADDR_W),
      .LANE_W  (LANE_W),
      .LANE_LSB(LANE_LSB),
      .SLOT_LSB(SLOT_LSB)
    ) u_node (
      .clk  (clk),
      .rst  (rst),
      .req  (acq_req[g]),
      .addr (acq_addr[g*ADDR_W +: ADDR_W]),
      .rel  (rel_req[g]),
      .phase(phase_q),
      .take (take[g]),
      .want (want[g]),
      .give (give[g]),
      .owns (owns[g]),
      .won  (won[g]),
      .lane (lanes[g*LANE_W +: LANE_W]),
      .slot (slots[g*SLOT_W +: SLOT_W])
    );
  end

  hmr_ring #(
    .NODES (NODES),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_ring (
    .clk    (clk),
    .rst    (rst),
    .want   (want),
    .give   (give),
    .lanes  (lanes),
    .slots  (slots),
    .take   (take),
    .ring_q (ring_q),
    .phase_q(phase_q)
  );

  assign ring_state = ring_q;
  assign ring_phase = phase_q;

  // holder map per token, drawn from node state for the R1 check
  logic [NODES-1:0] own_map [M];
  always_comb begin
    for (int m = 0; m < M; m++) begin
      for (int i = 0; i < NODES; i++) begin
        own_map[m][i] = owns[i] &&
          ({lanes[i*LANE_W +: LANE_W], slots[i*SLOT_W +: SLOT_W]} == IDX_W'(m));
      end
    end
  end

  for (genvar gm = 0; gm < M; gm++) begin : g_tok
    // R1: token is on the ring or with exactly one node
    a_r1_single_owner: assert property (@(posedge clk) disable iff (rst)
      ($countones(own_map[gm]) + (ring_q[gm] ? 1 : 0)) == 1);
  end
endmodule

// File: tb/hashed_mutex_ring_tb.sv
`timescale 1ns/1ps
module hashed_mutex_ring_tb;
  localparam int N  = 4;
  localparam int L  = 4;
  localparam int AW = 16;
  localparam int M  = L * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  acq_req = '0;
  logic [N*AW-1:0] acq_addr = '0;
  logic [N-1:0]  rel_req = '0;
  logic [N-1:0]  won;
  logic [M-1:0]  ring_state;
  logic [1:0]    ring_phase;

  int n_chk = 0;
  int n_bad = 0;
  int req_mutex [N];
  bit rel_pend [N];
  int owner [M];
  bit mon_en = 1'b0;

  always #2.5 clk = ~clk;

  hashed_mutex_ring u_dut (
    .clk(clk), .rst(rst), .acq_req(acq_req), .acq_addr(acq_addr),
    .rel_req(rel_req), .won(won), .ring_state(ring_state), .ring_phase(ring_phase)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] mk_addr(input int lane, input int slot, input int salt);
    logic [AW-1:0] a;
    a = AW'(salt * 1031);
    a[7:6] = 2'(slot);
    a[9:8] = 2'(lane);
    return a;
  endfunction

  function automatic int hash_of(input logic [AW-1:0] a);
    return int'(a[9:8]) * 4 + int'(a[7:6]);
  endfunction

  // bench-side ownership tracker (R1)
  always @(negedge clk) begin
    if (!rst && mon_en) begin
      for (int i = 0; i < N; i++) begin
        if (won[i]) begin
          int m;
          m = req_mutex[i];
          if (owner[m] != -1 && !rel_pend[owner[m]]) begin
            n_bad++;
            $display("FAIL R1 token %0d granted to node %0d actual_holder=%0d expected_holder=-1", m, i, owner[m]);
          end
          if (owner[m] != -1) rel_pend[owner[m]] = 1'b0;
          owner[m] = i;
        end
      end
      for (int m = 0; m < M; m++) begin
        n_chk++;
        if (ring_state[m]) begin
          if (owner[m] != -1 && !rel_pend[owner[m]]) begin
            n_bad++;
            $display("FAIL R1 token %0d on ring while held actual=1 expected=0", m);
          end
          if (owner[m] != -1) begin
            rel_pend[owner[m]] = 1'b0;
            owner[m] = -1;
          end
        end else if (owner[m] == -1) begin
          n_bad++;
          $display("FAIL R1 token %0d lost actual=0 expected=1", m);
        end
      end
    end
  end

  task automatic acq_start(input int i, input logic [AW-1:0] a);
    acq_addr[i*AW +: AW] = a;
    acq_req[i] = 1'b1;
    req_mutex[i] = hash_of(a);
  endtask

  task automatic acq_timed(input int i, input logic [AW-1:0] a);
    int d, m;
    acq_start(i, a);
    m = req_mutex[i];
    step();
    d = ((m % 4) - int'(ring_phase)) & 3;
    for (int k = 0; k < d; k++) begin
      step();
      chk(won[i] == 1'b0, "R4 early won", int'(won[i]), 0);
    end
    step();
    chk(won[i] == 1'b1, "R4 won on predicted edge", int'(won[i]), 1);
    chk(ring_state[m] == 1'b0, "R2 hashed bit cleared", int'(ring_state[m]), 0);
    acq_req[i] = 1'b0;
  endtask

  task automatic rel_timed(input int i);
    int d, m;
    m = req_mutex[i];
    rel_pend[i] = 1'b1;
    rel_req[i] = 1'b1;
    step();
    rel_req[i] = 1'b0;
    d = ((m % 4) - int'(ring_phase)) & 3;
    for (int k = 0; k < d; k++) begin
      step();
      chk(ring_state[m] == 1'b0, "R6 early return", int'(ring_state[m]), 0);
    end
    step();
    chk(ring_state[m] == 1'b1, "R6 return edge", int'(ring_state[m]), 1);
  endtask

  initial begin
    for (int m = 0; m < M; m++) owner[m] = -1;
    for (int i = 0; i < N; i++) begin req_mutex[i] = 0; rel_pend[i] = 1'b0; end
    repeat (3) step();
    // R7 reset values
    chk(ring_state == '1, "R7 ring after reset", int'(ring_state), 16'hffff);
    chk(won == '0, "R7 won after reset", int'(won), 0);
    chk(ring_phase == 2'd0, "R7 phase after reset", int'(ring_phase), 0);
    rst = 1'b0;
    mon_en = 1'b1;
    // R8 phase rotation
    for (int k = 0; k < 6; k++) begin
      int p;
      p = int'(ring_phase);
      step();
      chk(int'(ring_phase) == ((p + 1) & 3), "R8 phase step", int'(ring_phase), (p + 1) & 3);
    end

    // sweep: every node, every lane, every slot (R2, R3, R4, R6)
    for (int i = 0; i < N; i++) begin
      for (int ln = 0; ln < L; ln++) begin
        for (int sl = 0; sl < 4; sl++) begin
          int m;
          m = ln * 4 + sl;
          acq_timed(i, mk_addr(ln, sl, i * 16 + ln * 5 + sl));
          for (int k = 0; k < (i + sl) % 3; k++) step();
          chk(ring_state == ~(M'(1) << m), "R3 others untouched", int'(ring_state), int'(~(M'(1) << m)));
          rel_timed(i);
        end
      end
    end

    // R10: different lanes, same slot, both win together
    begin
      int d;
      acq_start(0, mk_addr(1, 2, 7));
      acq_start(2, mk_addr(3, 2, 9));
      step();
      d = (2 - int'(ring_phase)) & 3;
      for (int k = 0; k < d; k++) step();
      step();
      chk(won[0] && won[2], "R10 parallel lanes", int'(won), 5);
      acq_req[0] = 1'b0;
      acq_req[2] = 1'b0;
      rel_timed(0);
      rel_timed(2);
    end

    // R5 priority then R6 downstream hand-off in the same pass
    begin
      int d, m;
      acq_start(3, mk_addr(2, 1, 3));
      acq_start(1, mk_addr(2, 1, 11));
      m = 2 * 4 + 1;
      step();
      d = (1 - int'(ring_phase)) & 3;
      for (int k = 0; k < d; k++) step();
      step();
      chk(won[1] == 1'b1, "R5 lower index wins", int'(won[1]), 1);
      chk(won[3] == 1'b0, "R5 higher index waits", int'(won[3]), 0);
      acq_req[1] = 1'b0;
      rel_pend[1] = 1'b1;
      rel_req[1] = 1'b1;
      step();
      rel_req[1] = 1'b0;
      d = (1 - int'(ring_phase)) & 3;
      for (int k = 0; k < d; k++) begin
        step();
        chk(won[3] == 1'b0, "R6 hand-off too early", int'(won[3]), 0);
      end
      step();
      chk(won[3] == 1'b1, "R6 downstream same pass", int'(won[3]), 1);
      chk(ring_state[m] == 1'b0, "R6 token stays off ring", int'(ring_state[m]), 0);
      acq_req[3] = 1'b0;
      rel_timed(3);
    end

    // R6: upstream waiter gets the returned token only next rotation
    begin
      int d;
      acq_timed(2, mk_addr(0, 3, 21));
      acq_start(0, mk_addr(0, 3, 22));
      step();
      rel_timed(2);
      chk(won[0] == 1'b0, "R6 upstream not same pass", int'(won[0]), 0);
      for (int k = 0; k < 3; k++) begin
        step();
        chk(won[0] == 1'b0, "R6 upstream early", int'(won[0]), 0);
      end
      step();
      chk(won[0] == 1'b1, "R6 upstream next rotation", int'(won[0]), 1);
      acq_req[0] = 1'b0;
      rel_timed(0);
      d = 0;
    end

    // R9: stray release from an idle node
    begin
      logic [M-1:0] snap;
      snap = ring_state;
      rel_req[1] = 1'b1;
      step();
      rel_req[1] = 1'b0;
      repeat (4) step();
      chk(ring_state == snap, "R9 idle release ignored", int'(ring_state), int'(snap));
      chk(won == '0, "R9 no grant from release", int'(won), 0);
    end

    // R9: request while holding is ignored
    begin
      int z, w;
      acq_timed(0, mk_addr(1, 0, 31));
      z = 4;
      w = 3 * 4 + 2;
      acq_addr[0 +: AW] = mk_addr(3, 2, 32);
      acq_req[0] = 1'b1;
      repeat (6) step();
      chk(ring_state[w] == 1'b1, "R9 held node ignores new request", int'(ring_state[w]), 1);
      chk(ring_state == ~(M'(1) << z), "R9 only held token absent", int'(ring_state), int'(~(M'(1) << z)));
      acq_req[0] = 1'b0;
      rel_timed(0);
    end

    // R9: address change while waiting is ignored
    begin
      int a, b;
      a = 1 * 4 + 3;
      b = 2 * 4 + 0;
      acq_timed(3, mk_addr(1, 3, 41));
      acq_start(2, mk_addr(1, 3, 42));
      step();
      acq_addr[2*AW +: AW] = mk_addr(2, 0, 43);
      step();
      rel_timed(3);
      for (int k = 0; k < 3; k++) step();
      step();
      chk(won[2] == 1'b1, "R9 waiter wins captured token", int'(won[2]), 1);
      chk(ring_state[a] == 1'b0, "R9 captured token taken", int'(ring_state[a]), 0);
      chk(ring_state[b] == 1'b1, "R9 later address unused", int'(ring_state[b]), 1);
      acq_req[2] = 1'b0;
      rel_timed(2);
    end

    repeat (4) step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule